// File: doc/BRIEF.md
# I2C Control-Port Target with Strap-Selected Address

This block is the serial control port of a larger device. It runs entirely on a fast system clock and oversamples the two bus lines. A two-flop synchronizer and a short agreement filter clean each line. An edge detector then turns the clean lines into clock edges and bus conditions. A byte engine follows the transfer: it compares the first byte with the device address, takes in the header byte that always comes next, and then moves data bytes in either direction.

The device address pair is not fixed at build time. A strap input is captured while reset is held, and it selects one of two base addresses. The bus data line is open drain, so the block only ever reports whether it is pulling the line low.

On the register side, received bytes appear on one shared byte output. A single-cycle strobe marks each byte as either the header or a write-data byte. For reads, the block raises a one-cycle request and takes the byte to be sent from `rd_data` on the next system clock.

Top module: `ctl_i2c_target`

## Requirements
- R1: A STOP (SDA rising while SCL is high) is recognised in any state, including in the middle of a byte. It discards any partial byte, returns the block to idle with `sda_pull` low, and later bytes get no acknowledge until a START.
- R2: Bits are taken on the rising SCL edge, most significant bit first. A completed header or write byte is presented on `rx_byte` in that bit order.
- R3: The strap level captured during reset selects the address pair. Strap 0 gives write address 0xC2 and read address 0xC3. Strap 1 gives write address 0xC8 and read address 0xC9. Bit 0 of the address byte is the direction, with 1 meaning read. A strap change after reset has no effect. A matching address is acknowledged by `sda_pull` = 1 during the ninth SCL pulse.
- R4: A non-matching address gets no acknowledge. Every later byte up to the next START or STOP gets no acknowledge and produces no strobe and no read request.
- R5: After an accepted address, in both directions, the next byte is the header. It is acknowledged and announced by a one-cycle `hdr_stb`. `hdr_stb`, `wr_stb` and `rd_req` are never high together.
- R6: In a write, any number of data bytes may follow the header. Each one is acknowledged and announced by a one-cycle `wr_stb`.
- R7: In a read, `rd_req` pulses once, after the falling SCL edge that ends an acknowledged ninth slot. This applies to the header's slot and to each master acknowledge. `rd_data` is taken on the clock after the pulse and sent most significant bit first: a 0 bit drives `sda_pull` = 1 and a 1 bit drives `sda_pull` = 0. The line is released during the master's acknowledge slot.
- R8: In a read, SDA high in the ninth slot (master not acknowledging) ends the transfer as a STOP would. No further `rd_req` is raised, the line stays released, and later bytes are not acknowledged until a START.
- R9: A START (SDA falling while SCL is high) in the middle of a transfer restarts address reception at once, with no STOP needed first.
- R10: A pulse lasting one system clock on either SCL or SDA has no effect on the transfer.
- R11: `sda_pull` changes only while SCL is low, except for the release caused by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL bit rate |
| rst_n | input | 1 | Active-low reset; the strap is captured while it is low |
| addr_sel_strap | input | 1 | Address pair select, sampled during reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| rd_data | input | 8 | Byte to send, valid on the clock after `rd_req` |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release the line |
| rx_byte | output | 8 | Last header or write byte received |
| hdr_stb | output | 1 | One-cycle pulse: `rx_byte` holds the header |
| wr_stb | output | 1 | One-cycle pulse: `rx_byte` holds a write-data byte |
| rd_req | output | 1 | One-cycle request for the next read byte |

## Verification
The hardest situations to reach from the ports are those where the bus is cut short or restarted mid-byte:
- a STOP after a few bits;
- a repeated START after half a data byte;
- a master that refuses the last read byte and then keeps clocking.

Each needs a bit-level master model rather than whole-byte transfers. The bench's master tasks can therefore stop after any number of bits and then issue a START or STOP from the low phase. They also inject one-cycle spikes on either line during the high phase of SCL.

Random transfers with random directions, headers and byte counts run between these directed cases. They confirm that a cut-short transfer leaves no stale state behind.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HDR,
    ST_WR,
    ST_RD,
    ST_SKIP
  } xfer_st_t;

  // Choose the write address of the pair selected by the strap.
  function automatic logic [BYTE_W-1:0] pick_wr_addr(input logic sel,
                                                      input logic [BYTE_W-1:0] base_lo,
                                                      input logic [BYTE_W-1:0] base_hi);
    return sel ? base_hi : base_lo;
  endfunction

  // An address byte hits when its upper seven bits equal the device address.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [BYTE_W-1:0] wr_addr);
    return rx[BYTE_W-1:1] == wr_addr[BYTE_W-1:1];
  endfunction

endpackage

// File: rtl/ctl_i2c_line_filter.sv
module ctl_i2c_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 2,
  parameter logic RST_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   sync_out;
  logic                   filt_q;

  assign sync_out = sync_q[SYNC_STAGES-1];
  assign filt     = filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{RST_VAL}};
      hist_q <= {FILT_LEN{RST_VAL}};
      filt_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_out};
      if (&hist_q)       filt_q <= 1'b1;
      else if (~|hist_q) filt_q <= 1'b0;
    end
  end

  // A new filtered level must have been seen on the synchronized line on two
  // consecutive samples.
  AST_FILT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> ($past(sync_out, 2) == filt_q && $past(sync_out, 3) == filt_q)); // R10

endmodule

// File: rtl/ctl_i2c_cond_detect.sv
module ctl_i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/ctl_i2c_xfer_engine.sv
module ctl_i2c_xfer_engine
  import ctl_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] my_addr,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              hdr_stb,
  output logic              wr_stb,
  output logic              rd_req
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  xfer_st_t          st, pend_st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, data_q;
  logic              pull_q, load_pend, is_read;
  logic              hdr_q, wr_q, req_q;

  // Named internal events, used by the sequential logic and the assertions.
  logic active, byte_done, ack_end, ack_rise, master_nack;

  assign active      = (st == ST_ADDR) || (st == ST_HDR) || (st == ST_WR) || (st == ST_RD);
  assign byte_done   = active && scl_fall && (bit_cnt == CNT_BYTE);
  assign ack_end     = active && scl_fall && (bit_cnt == CNT_ACK);
  assign ack_rise    = active && scl_rise && (bit_cnt == CNT_BYTE);
  assign master_nack = ack_rise && (st == ST_RD) && sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend_st   <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      data_q    <= '0;
      pull_q    <= 1'b0;
      load_pend <= 1'b0;
      is_read   <= 1'b0;
      hdr_q     <= 1'b0;
      wr_q      <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      hdr_q <= 1'b0;
      wr_q  <= 1'b0;
      req_q <= 1'b0;
      if (start_det) begin
        st        <= ST_ADDR;
        bit_cnt   <= '0;
        pull_q    <= 1'b0;
        load_pend <= 1'b0;
      end else if (stop_det) begin
        st        <= ST_IDLE;
        bit_cnt   <= '0;
        pull_q    <= 1'b0;
        load_pend <= 1'b0;
      end else begin
        if (load_pend) begin
          tx_sh     <= {rd_data[BYTE_W-2:0], 1'b0};
          pull_q    <= ~rd_data[BYTE_W-1];
          load_pend <= 1'b0;
        end
        if (active && scl_rise) begin
          if (bit_cnt < CNT_BYTE) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (master_nack) begin
            st <= ST_IDLE;
          end else if (bit_cnt == CNT_BYTE) begin
            bit_cnt <= CNT_ACK;
          end
        end
        if (byte_done) begin
          case (st)
            ST_ADDR: begin
              if (addr_hit(rx_sh, my_addr)) begin
                pull_q  <= 1'b1;
                is_read <= rx_sh[0];
                pend_st <= ST_HDR;
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_HDR: begin
              pull_q  <= 1'b1;
              hdr_q   <= 1'b1;
              data_q  <= rx_sh;
              pend_st <= is_read ? ST_RD : ST_WR;
            end
            ST_WR: begin
              pull_q  <= 1'b1;
              wr_q    <= 1'b1;
              data_q  <= rx_sh;
              pend_st <= ST_WR;
            end
            default: begin
              pull_q  <= 1'b0;
              pend_st <= ST_RD;
            end
          endcase
        end else if (ack_end) begin
          pull_q  <= 1'b0;
          bit_cnt <= '0;
          st      <= pend_st;
          if (pend_st == ST_RD) begin
            req_q     <= 1'b1;
            load_pend <= 1'b1;
          end
        end else if (active && scl_fall && st == ST_RD && bit_cnt != '0) begin
          pull_q <= ~tx_sh[BYTE_W-1];
          tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sda_pull = pull_q;
  assign rx_byte  = data_q;
  assign hdr_stb  = hdr_q;
  assign wr_stb   = wr_q;
  assign rd_req   = req_q;

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !pull_q)); // R1
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR && bit_cnt == '0)); // R9
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> (!pull_q && !hdr_q && !wr_q && !req_q)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_q, wr_q, req_q})); // R5
  AST_REQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (st == ST_RD)); // R7
  AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    master_nack |=> (st == ST_IDLE && !req_q)); // R8
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pull_q) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_f)); // R11

endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target
  import ctl_i2c_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR_LO     = 8'hC2,
  parameter logic [BYTE_W-1:0] ADDR_HI     = 8'hC8,
  parameter int                SYNC_STAGES = 2,
  parameter int                FILT_LEN    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel_strap,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              hdr_stb,
  output logic              wr_stb,
  output logic              rd_req
);

  localparam int N_LINES = 2;

  logic              strap_q;
  logic [BYTE_W-1:0] my_addr;
  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  // The strap is sampled for as long as reset is held and then kept.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= addr_sel_strap;
  end

  assign my_addr   = pick_wr_addr(strap_q, ADDR_LO, ADDR_HI);
  assign raw_lines = {sda_i, scl_i};

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
    ctl_i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .RST_VAL    (1'b1)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[gi]),
      .filt (clean_lines[gi])
    );
  end

  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  ctl_i2c_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_evt),
    .stop_det (stop_evt)
  );

  ctl_i2c_xfer_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .my_addr  (my_addr),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_evt),
    .stop_det (stop_evt),
    .rd_data  (rd_data),
    .sda_pull (sda_pull),
    .rx_byte  (rx_byte),
    .hdr_stb  (hdr_stb),
    .wr_stb   (wr_stb),
    .rd_req   (rd_req)
  );

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt) && !(scl_rise && (start_evt || stop_evt))); // R1

endmodule

// File: tb/ctl_i2c_target_test.sv
module ctl_i2c_target_test;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, scl_gl = 1'b0, sda_gl = 1'b0;
  logic sda_pull, hdr_stb, wr_stb, rd_req;
  logic [7:0] rx_byte;
  logic [7:0] rd_data = 8'h00;
  wire scl_i = scl_m & ~scl_gl;
  wire sda_i = (sda_m ^ sda_gl) & ~sda_pull;

  int checks = 0, fails = 0, rd_cnt = 0, pull_bad = 0;
  bit done = 0;
  logic pull_prev = 1'b0;
  logic [7:0] hdr_log[$];
  logic [7:0] wr_log[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_i2c_target uut (
    .clk(clk), .rst_n(rst_n), .addr_sel_strap(strap), .scl_i(scl_i), .sda_i(sda_i),
    .rd_data(rd_data), .sda_pull(sda_pull), .rx_byte(rx_byte), .hdr_stb(hdr_stb),
    .wr_stb(wr_stb), .rd_req(rd_req)
  );

  function automatic logic [7:0] rd_model(input int idx);
    return 8'((idx * 29) ^ 8'h6D);
  endfunction

  function automatic bit exp_hit(input logic [7:0] a, input bit s);
    return a[7:1] == (s ? 7'h64 : 7'h61);
  endfunction

  // Register-side model and the R11 line monitor, away from the active edge.
  always @(negedge clk) begin
    if (hdr_stb) hdr_log.push_back(rx_byte);
    if (wr_stb) wr_log.push_back(rx_byte);
    if (rd_req) begin
      rd_data = rd_model(rd_cnt);
      rd_cnt++;
    end
    if (rst_n && scl_i && sda_pull !== pull_prev) pull_bad++;
    pull_prev = sda_pull;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit s);
    rst_n = 1'b0; strap = s; scl_m = 1'b1; sda_m = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    strap = ~s;
    tick(4);
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic clk_bit(input bit b, input bit glitch, output bit seen);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2);
    if (glitch) begin
      if (b) scl_gl = 1'b1; else sda_gl = 1'b1;
      tick(1); scl_gl = 1'b0; sda_gl = 1'b0;
    end else tick(1);
    tick(Q - 3); seen = sda_i; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch, s);
    clk_bit(1'b1, 1'b0, s);
    acked = !s;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b0, s);
      b[i] = s;
    end
    clk_bit(!give_ack, 1'b0, s);
  endtask

  task automatic do_write(input bit s, input int n);
    logic [7:0] h, d;
    logic [7:0] sent[$];
    bit a;
    hdr_log.delete(); wr_log.delete();
    start_c();
    put_byte(s ? 8'hC8 : 8'hC2, 1'b0, a);
    chk(a == 1'b1, "R3", "write address ack", a, 1);
    h = 8'($urandom);
    put_byte(h, 1'b0, a);
    chk(a == 1'b1, "R5", "header ack", a, 1);
    for (int j = 0; j < n; j++) begin
      d = 8'($urandom);
      sent.push_back(d);
      put_byte(d, 1'b0, a);
      chk(a == 1'b1, "R6", "data byte ack", a, 1);
    end
    stop_c();
    chk(hdr_log.size() == 1 && hdr_log[0] == h, "R2", "header byte msb first",
        hdr_log.size() ? hdr_log[0] : 32'hFFFF, h);
    chk(wr_log.size() == n, "R6", "write strobe count", wr_log.size(), n);
    for (int j = 0; j < n && j < wr_log.size(); j++)
      chk(wr_log[j] == sent[j], "R6", "write data", wr_log[j], sent[j]);
  endtask

  task automatic do_read(input bit s, input int k);
    logic [7:0] b;
    int base;
    bit a;
    hdr_log.delete();
    base = rd_cnt;
    start_c();
    put_byte(s ? 8'hC9 : 8'hC3, 1'b0, a);
    chk(a == 1'b1, "R3", "read address ack", a, 1);
    put_byte(8'($urandom), 1'b0, a);
    chk(a == 1'b1 && hdr_log.size() == 1, "R5", "read header ack and strobe", a, 1);
    for (int j = 0; j < k; j++) begin
      get_byte(j < k - 1, b);
      chk(b == rd_model(base + j), "R7", "read byte", b, rd_model(base + j));
    end
    tick(4);
    chk(rd_cnt - base == k && sda_pull == 1'b0, "R8", "requests after nack",
        rd_cnt - base, k);
    stop_c();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    bit a;
    int r0;
    void'($urandom(32'd2024));
    do_reset(1'b0);
    chk(sda_pull == 1'b0 && !hdr_stb && !wr_stb && !rd_req, "R1", "reset outputs",
        {sda_pull, hdr_stb, wr_stb, rd_req}, 0);

    // Directed: strap 0, plain write and read.
    do_write(1'b0, 3);
    do_read(1'b0, 3);

    // R4: wrong address pair, no ack and no strobes.
    hdr_log.delete(); wr_log.delete(); r0 = rd_cnt;
    start_c();
    put_byte(8'hC8, 1'b0, a);
    chk(a == 1'b0, "R4", "foreign address nack", a, 0);
    put_byte(8'h12, 1'b0, a);
    chk(a == 1'b0, "R4", "byte after foreign address", a, 0);
    stop_c();
    start_c();
    put_byte(8'hC9, 1'b0, a);
    put_byte(8'h00, 1'b0, a);
    chk(a == 1'b0, "R4", "byte after foreign read address", a, 0);
    stop_c();
    chk(hdr_log.size() + wr_log.size() + (rd_cnt - r0) == 0, "R4", "strobes while ignored",
        hdr_log.size() + wr_log.size(), 0);

    // R8: nack, then more clocks without STOP.
    r0 = rd_cnt;
    start_c();
    put_byte(8'hC3, 1'b0, a);
    put_byte(8'h55, 1'b0, a);
    get_byte(1'b0, b);
    chk(b == rd_model(r0), "R7", "single read byte", b, rd_model(r0));
    get_byte(1'b1, b);
    chk(b == 8'hFF && rd_cnt - r0 == 1, "R8", "bus released after nack", b, 8'hFF);
    put_byte(8'hC3, 1'b0, a);
    chk(a == 1'b0, "R8", "no ack after nack", a, 0);
    stop_c();

    // R1: STOP after three bits of a header.
    hdr_log.delete();
    start_c();
    put_byte(8'hC2, 1'b0, a);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, 1'b0, a);
    stop_c();
    put_byte(8'hC2, 1'b0, a);
    chk(a == 1'b0, "R1", "no ack after mid-byte stop", a, 0);
    chk(hdr_log.size() == 0, "R1", "partial byte discarded", hdr_log.size(), 0);
    stop_c();

    // R9: repeated START in the middle of a data byte.
    hdr_log.delete(); wr_log.delete(); r0 = rd_cnt;
    start_c();
    put_byte(8'hC2, 1'b0, a);
    put_byte(8'hA1, 1'b0, a);
    put_byte(8'h3C, 1'b0, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, a);
    start_c();
    put_byte(8'hC3, 1'b0, a);
    chk(a == 1'b1, "R9", "address after repeated start", a, 1);
    put_byte(8'h7E, 1'b0, a);
    get_byte(1'b0, b);
    stop_c();
    chk(hdr_log.size() == 2 && hdr_log[1] == 8'h7E, "R9", "second header",
        hdr_log.size(), 2);
    chk(wr_log.size() == 1 && wr_log[0] == 8'h3C, "R9", "only whole write byte kept",
        wr_log.size(), 1);
    chk(b == rd_model(r0), "R9", "read after repeated start", b, rd_model(r0));

    // R10: one-cycle spikes on both lines during high phases.
    wr_log.delete();
    start_c();
    put_byte(8'hC2, 1'b0, a);
    put_byte(8'h0F, 1'b1, a);
    chk(a == 1'b1, "R10", "header ack with spikes", a, 1);
    put_byte(8'hB4, 1'b1, a);
    chk(a == 1'b1, "R10", "data ack with spikes", a, 1);
    stop_c();
    chk(wr_log.size() == 1 && wr_log[0] == 8'hB4, "R10", "data under spikes",
        wr_log.size() ? wr_log[0] : 32'hFFFF, 8'hB4);

    // Random transfers.
    for (int t = 0; t < 6; t++) begin
      if ($urandom % 2) do_write(1'b0, 1 + int'($urandom % 5));
      else do_read(1'b0, 1 + int'($urandom % 4));
    end

    // R3: strap 1 selects the other pair; strap moves after reset.
    do_reset(1'b1);
    start_c();
    put_byte(8'hC2, 1'b0, a);
    chk(a == exp_hit(8'hC2, 1'b1), "R3", "low pair refused under strap 1", a, 0);
    stop_c();
    do_write(1'b1, 2);
    do_read(1'b1, 2);

    chk(pull_bad == 0, "R11", "pull changes with SCL high", pull_bad, 0);
    done = 1;
    summary();
    $finish;
  end

endmodule